// File: doc/BRIEF.md
# FIFO Read-Side Output Stage with Fall-Through and Standard Modes

This block is the read side of a single-clock FIFO holding words of `DATA_W` bits, 36 by default. Writes go into a storage array of `DEPTH` words. Reads come out of a registered output word, `rd_data`, that sits after the array. A mode pin is captured while reset is held. It selects one of two read disciplines that share the same array.

- **Fall-through mode:** the head word is moved into the output register without any request, and `rd_ready` is an output-ready flag. It is high when `rd_data` holds a word that has not yet been consumed.
- **Standard mode:** the output register loads only on an explicit read, and `rd_ready` is an active-low empty flag. It is high when words are stored, and it rises on the second clock edge after the first write.

A read is requested through four qualifiers: an active-low chip select, a direction bit, an enable and a mailbox-select bit. Only one combination of these counts as a read.

The controller is a three-state machine:
- **EMPTY:** no word is presented and `rd_ready` is low.
- **ARM:** standard mode only. It covers the one edge between seeing stored data and raising the flag.
- **READY:** `rd_ready` is high.

The transitions are:
- **fill:** EMPTY to READY in fall-through mode, loading the head word.
- **arm:** EMPTY to ARM in standard mode.
- **settle:** ARM to READY.
- **advance:** READY to READY on a read that loads a new word.
- **drain:** READY to EMPTY on a read that leaves nothing behind.

Top module: `fifo_out_stage`

## Requirements
- R1: A read is selected only when `rd_cs_n`=0, `rd_dir`=1, `rd_en`=1 and `rd_mbox`=0. Any other combination performs no read, and `rd_data` and `rd_ready` are unaffected by it.
- R2: `fwft_sel` (1 = fall-through, 0 = standard) is captured only while `rst_n` is low. Changing it after reset has no effect on behaviour.
- R3: An asynchronous active-low reset clears the pointers and the count, drives `rd_ready` low and clears `rd_data` to zero.
- R4: In fall-through mode with `rd_ready` low, a word written at edge k is loaded into `rd_data` at edge k+1, the same edge that raises `rd_ready`.
- R5: In fall-through mode with `rd_ready` high, `rd_data` changes only at an edge with a selected read, which loads the next stored word.
- R6: In fall-through mode, a selected read with no further word stored drives `rd_ready` low at that edge, and `rd_data` keeps its last value.
- R7: In standard mode, the first word written into an empty FIFO at edge k raises `rd_ready` at edge k+2. `rd_data` is not loaded by this.
- R8: In standard mode, a selected read while `rd_ready` is high loads the oldest stored word into `rd_data` at that edge. `rd_ready` falls at that edge if the word was the last stored one and no write is accepted at the same edge.
- R9: A selected read while `rd_ready` is low is ignored. `rd_data`, the pointers and the later read order are unchanged.
- R10: A write is accepted only while fewer than `DEPTH` words are held in the array, and words leave in the order they were accepted. A word held in the output register does not count towards the `DEPTH` words in the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwft_sel | input | 1 | Mode select captured during reset: 1 = fall-through, 0 = standard |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_cs_n | input | 1 | Read chip select, active low |
| rd_dir | input | 1 | Direction, 1 = read |
| rd_en | input | 1 | Read enable |
| rd_mbox | input | 1 | Mailbox select, must be 0 for a FIFO read |
| rd_data | output | DATA_W | Output register |
| rd_ready | output | 1 | Output-ready (fall-through) or empty, active low (standard) |

## Verification
The timing of each result is as follows:
- A selected read changes `rd_data` and `rd_ready` at the same rising edge it is applied on.
- A write into an empty FIFO shows on `rd_ready` one edge later in fall-through mode and two edges later in standard mode.
- A dropped write or an ignored read shows only through later read data.

The bench drives all inputs on the falling edge. It steps a reference model once per rising edge, using the inputs applied at that edge. It compares both outputs at the next falling edge, so every latency is checked on the exact edge it is due. Random traffic with a fixed seed is mixed with directed fill, overflow and drain runs in both modes, plus a run with the mode pin toggled after reset.

// File: rtl/fos_pkg.sv
package fos_pkg;
    typedef enum logic [1:0] {
        FOS_EMPTY = 2'd0,
        FOS_ARM   = 2'd1,
        FOS_READY = 2'd2
    } fos_state_t;
endpackage

// File: rtl/fos_rdsel.sv
module fos_rdsel (
    input  logic cs_n,
    input  logic dir,
    input  logic en,
    input  logic mbox,
    output logic sel
);
    // A FIFO read needs all four qualifiers in their read state.
    assign sel = !cs_n && dir && en && !mbox;
endmodule

// File: rtl/fos_store.sv
module fos_store #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         room
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr, wptr_nx, rptr_nx;

    // Pointer wrap: a power-of-two depth wraps by overflow, otherwise by compare.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
            assign wptr_nx = wptr + 1'b1;
            assign rptr_nx = rptr + 1'b1;
        end else begin : g_wrap_cmp
            localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
            assign wptr_nx = (wptr == LAST) ? '0 : wptr + 1'b1;
            assign rptr_nx = (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    endgenerate

    assign head = mem[rptr];
    assign room = (count < CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr_nx;
            if (pop)  rptr <= rptr_nx;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_pop_has_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    p_full_blocks_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/fos_ctrl.sv
module fos_ctrl
    import fos_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic             rd_sel,
    input  logic             push_ok,
    input  logic [CNT_W-1:0] count,
    output logic             pop,
    output logic             ready,
    output logic             fwft,
    output fos_state_t       state
);
    fos_state_t nxt;
    logic       mode_q;

    // Mode capture: follows the pin only while reset is held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= mode_in;
        else        mode_q <= mode_q;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FOS_EMPTY;
        else        state <= nxt;
    end

    // Next state and strobes.
    always_comb begin
        nxt = state;
        pop = 1'b0;
        unique case (state)
            FOS_EMPTY: begin
                if (count != '0) begin
                    if (mode_q) begin
                        nxt = FOS_READY;          // fill
                        pop = 1'b1;
                    end else begin
                        nxt = FOS_ARM;            // arm
                    end
                end
            end
            FOS_ARM: begin
                nxt = FOS_READY;                  // settle
            end
            FOS_READY: begin
                if (rd_sel) begin
                    if (mode_q) begin
                        if (count != '0) pop = 1'b1;          // advance
                        else             nxt = FOS_EMPTY;     // drain
                    end else begin
                        pop = 1'b1;                           // advance
                        if (count == CNT_W'(1) && !push_ok)
                            nxt = FOS_EMPTY;                  // drain
                    end
                end
            end
            default: nxt = FOS_EMPTY;
        endcase
    end

    assign ready = (state == FOS_READY);
    assign fwft  = mode_q;

    p_std_rise_after_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && state == FOS_ARM) |=> ready);

    p_std_empty_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && state != FOS_READY) |-> !pop);

    p_fwft_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && state == FOS_EMPTY && count != '0) |=> ready);

    p_fwft_no_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (state != FOS_ARM));

    p_std_ready_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && ready) |-> (count != '0));
endmodule

// File: rtl/fos_outreg.sv
module fos_outreg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
    import fos_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_cs_n,
    input  logic              rd_dir,
    input  logic              rd_en,
    input  logic              rd_mbox,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              rd_sel, room, push, pop, fwft;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] head;
    fos_state_t        state;

    assign push = wr_en && room;

    fos_rdsel u_rdsel (
        .cs_n (rd_cs_n),
        .dir  (rd_dir),
        .en   (rd_en),
        .mbox (rd_mbox),
        .sel  (rd_sel)
    );

    fos_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .room      (room)
    );

    fos_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (fwft_sel),
        .rd_sel  (rd_sel),
        .push_ok (push),
        .count   (count),
        .pop     (pop),
        .ready   (rd_ready),
        .fwft    (fwft),
        .state   (state)
    );

    fos_outreg #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pop),
        .din   (head),
        .q     (rd_data)
    );

    p_fwft_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && state == FOS_READY && !rd_sel) |=> $stable(rd_data));

    p_fwft_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && rd_ready && rd_sel && count == '0) |=> (!rd_ready && $stable(rd_data)));

    p_ignored_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !rd_ready) |=> $stable(rd_data));

    p_no_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && !rd_sel && !(fwft && state == FOS_EMPTY)) |=> (rd_ready && $stable(rd_data)));
endmodule

// File: tb/fifo_out_stage_tb_top.sv
module fifo_out_stage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 36;
    localparam int DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_sel = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_cs_n = 1'b1, rd_dir = 1'b0, rd_en = 1'b0, rd_mbox = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_ready;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model state
    logic [DW-1:0] mq[$];
    int            mst;          // 0 empty, 1 arm, 2 ready
    logic [DW-1:0] mout;
    logic          mmode;
    string         tag;
    logic          r2_phase = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_out_stage #(.DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_cs_n(rd_cs_n), .rd_dir(rd_dir), .rd_en(rd_en), .rd_mbox(rd_mbox),
        .rd_data(rd_data), .rd_ready(rd_ready)
    );

    function automatic logic is_sel(logic c, logic d, logic e, logic m);
        return !c && d && e && !m;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge with the given inputs.
    task automatic model_step(logic w, logic [DW-1:0] d, logic sel, logic partial);
        logic wacc;
        wacc = w && (mq.size() < DP);
        tag = mmode ? "R5" : "R8";
        if (partial && mst == 2) tag = "R1";
        if (sel && mst != 2) tag = "R9";
        if (mmode) begin
            if (mst == 0) begin
                if (mq.size() > 0) begin mout = mq.pop_front(); mst = 2; tag = "R4"; end
            end else if (mst == 2 && sel) begin
                if (mq.size() > 0) mout = mq.pop_front();
                else begin mst = 0; tag = "R6"; end
            end
        end else begin
            if (mst == 0) begin
                if (mq.size() > 0) begin mst = 1; tag = "R7"; end
            end else if (mst == 1) begin
                mst = 2; tag = "R7";
            end else if (sel) begin
                mout = mq.pop_front();
                if (mq.size() == 0 && !wacc) mst = 0;
            end
        end
        if (w && !wacc) tag = "R10";
        if (wacc) mq.push_back(d);
        if (r2_phase) tag = "R2";
    endtask

    // Drive inputs at a falling edge, take one rising edge, compare at the next falling edge.
    task automatic step(logic w, logic [DW-1:0] d, logic c, logic dr, logic e, logic m);
        logic sel;
        wr_en = w; wr_data = d; rd_cs_n = c; rd_dir = dr; rd_en = e; rd_mbox = m;
        sel = is_sel(c, dr, e, m);
        model_step(w, d, sel, !sel && (!c || dr || e || !m));
        @(posedge clk);
        @(negedge clk);
        check({tag, " flag"}, DW'(rd_ready), DW'(mst == 2));
        check({tag, " data"}, rd_data, mout);
    endtask

    task automatic do_reset(logic m);
        @(negedge clk);
        rst_n = 1'b0; fwft_sel = m;
        wr_en = 1'b0; rd_cs_n = 1'b1; rd_dir = 1'b0; rd_en = 1'b0; rd_mbox = 1'b0;
        repeat (2) @(negedge clk);
        mq.delete(); mst = 0; mout = '0; mmode = m;
        rst_n = 1'b1;
        // R3: reset state
        check("R3 flag", DW'(rd_ready), '0);
        check("R3 data", rd_data, '0);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'({4'($urandom), $urandom});
    endfunction

    task automatic idle();
        step(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(logic w, logic [DW-1:0] d);
        step(w, d, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 3) != 0, rnd_word(),
                 ($urandom % 8) == 0, ($urandom % 8) != 0,
                 ($urandom % 8) != 0, ($urandom % 8) == 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Fall-through directed: R4 latency, R5 hold, R1 partial selects, R6 drain, R9
        do_reset(1'b1);
        step(1'b1, 36'h1_2345_6789, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 flag low after write edge", DW'(rd_ready), '0);
        idle();
        check("R4 word loaded", rd_data, 36'h1_2345_6789);
        step(1'b1, 36'h2_0000_0002, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 no read on partial select", rd_data, 36'h1_2345_6789);
        rd(1'b0, '0);
        check("R5 next word", rd_data, 36'h2_0000_0002);
        rd(1'b0, '0);
        check("R6 data held on drain", rd_data, 36'h2_0000_0002);
        check("R6 flag low", DW'(rd_ready), '0);
        rd(1'b0, '0);
        // R10 overflow: DP+3 writes, then drain all
        for (int i = 0; i < DP + 3; i++) step(1'b1, DW'(i + 100), 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DP + 3; i++) rd(1'b0, '0);
        random_run(3000);

        // Standard directed: R7 two-edge latency, R8 reads, R9 ignored
        do_reset(1'b0);
        rd(1'b0, '0);
        step(1'b1, 36'h0_AAAA_5555, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 flag low edge k", DW'(rd_ready), '0);
        idle();
        check("R7 flag low edge k+1", DW'(rd_ready), '0);
        check("R7 data not loaded", rd_data, '0);
        idle();
        check("R7 flag high edge k+2", DW'(rd_ready), 36'd1);
        rd(1'b0, '0);
        check("R8 word read", rd_data, 36'h0_AAAA_5555);
        check("R8 flag low after last", DW'(rd_ready), '0);
        rd(1'b0, '0);
        check("R9 ignored read", rd_data, 36'h0_AAAA_5555);
        for (int i = 0; i < DP + 2; i++) step(1'b1, DW'(i + 500), 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DP + 2; i++) rd(1'b0, '0);
        random_run(3000);

        // R2: mode pin toggled after reset must not matter
        do_reset(1'b1);
        fwft_sel = 1'b0;
        r2_phase = 1'b1;
        random_run(1500);
        do_reset(1'b0);
        fwft_sel = 1'b1;
        random_run(1500);
        r2_phase = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule